// File: doc/BRIEF.md
# Outbound Packet Arbiter with Priority Completions and Fair Bulk Rotation

This block decides which of several packet producers may next drive the single 64-bit outbound stream that feeds the link transaction layer. There are two classes of producer. The completion source, which answers host reads of device registers, has absolute precedence. Below it, the bulk producers take turns in a fair rotation. By default there are three of them: bulk index 0 issues DMA memory read requests, index 1 issues DMA memory write requests, and index 2 issues device-initiated writes to an arbitrary bus address.

Every producer and the outbound port use a valid/ready stream with a last-beat marker. A beat moves when valid and ready are both high at a rising clock edge. The arbiter changes owner only between packets. Once the first beat of a packet has been accepted, the stream stays with that producer until its last beat has been accepted. The arbiter forwards back-pressure from the outbound port straight to the owning producer. When the outbound port lowers ready, no producer sees ready. The arbiter has no inbound-side input, so it can never stall waiting for received traffic.

Data passes through combinationally. A decision made at a packet boundary takes effect in the same cycle it is made.

Top module: `tx_pkt_sched`

## Requirements
- R1: When no producer presents valid, out_valid is low; after reset no producer sees ready until one presents valid.
- R2: At a packet boundary, a valid completion (cpl_valid high) is granted ahead of every bulk producer.
- R3: Bulk producers that are all continuously valid are served one whole packet each, in ascending bulk index order (0, 1, 2, then 0 again), starting from index 0 after reset.
- R4: Finishing a bulk packet from index i moves the rotation so that index i+1 (wrapping to 0) is preferred next; finishing a completion packet leaves the rotation unchanged.
- R5: Once the first beat of a packet is accepted, every beat up to and including the one with last high comes from that same producer, and no other producer sees ready.
- R6: A completion that becomes valid in the middle of a bulk packet waits until that packet's last beat is accepted, then wins the next decision.
- R7: At most one producer sees ready at a time, and out_data and out_last equal the data and last of the producer whose ready is high.
- R8: While out_ready is low, no producer sees ready and the arbiter state does not move, so packet order is independent of back-pressure.
- R9: At a packet boundary the rotation skips idle bulk producers and grants the first valid one at or after the preferred index, so out_valid is high whenever any producer is valid and out_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| cpl_valid | input | 1 | Completion producer has a beat |
| cpl_data | input | DATA_W | Completion beat data |
| cpl_last | input | 1 | Completion beat ends its packet |
| cpl_ready | output | 1 | Completion beat accepted this cycle if valid |
| bulk_valid | input | N_BULK | Per bulk producer: beat present (bit i = bulk index i) |
| bulk_data | input | N_BULK*DATA_W | Bulk beat data, index i in bits [i*DATA_W +: DATA_W] |
| bulk_last | input | N_BULK | Per bulk producer: beat ends its packet |
| bulk_ready | output | N_BULK | Per bulk producer: beat accepted this cycle if valid |
| out_valid | output | 1 | Outbound beat present |
| out_data | output | DATA_W | Outbound beat data |
| out_last | output | 1 | Outbound beat ends its packet |
| out_ready | input | 1 | Downstream accepts the outbound beat |

## Verification
The hardest situation to reach from the ports is a completion that arrives while a bulk packet is only partly through. To reach it, the bench starts a six-beat bulk packet, waits two accepted beats, and then raises a completion together with another bulk packet. The expected order (rest of the bulk packet, then the completion, then the other bulk packet) must appear exactly. A second difficult case is a completion winning while the rotation pointer sits mid-rotation. The bench steers the pointer there with a single lone bulk packet, then offers the completion and two other bulk producers at once. This shows both that the completion leaves the pointer alone and that idle indices are skipped. Finally, a pseudo-random out_ready pattern runs over a mixed batch to show that back-pressure changes timing but not order.

// File: rtl/tx_arb_pkg.sv
package tx_arb_pkg;

  // Ownership state of the outbound stream.
  typedef enum logic {
    HOLD_OPEN = 1'b0,
    HOLD_BUSY = 1'b1
  } hold_e;

  // Width of an index into n items, at least one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/tx_rr_pick.sv
module tx_rr_pick #(
  parameter int unsigned N  = 3,
  parameter int unsigned PW = 2
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic [N-1:0]  gnt
);

  // Scan from the preferred index upward, wrapping, and take the first request.
  always_comb begin
    logic        found;
    int unsigned idx;
    gnt   = '0;
    found = 1'b0;
    idx   = 0;
    for (int unsigned k = 0; k < N; k++) begin
      idx = (32'(ptr) + k) % N;
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_arb_ctrl.sv
module tx_arb_ctrl
  import tx_arb_pkg::*;
#(
  parameter int unsigned N  = 3,
  parameter int unsigned PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpl_req,
  input  logic [N-1:0]  rr_gnt,
  input  logic          fire,
  input  logic          fire_last,
  output logic [PW-1:0] ptr,
  output logic [N:0]    sel
);

  hold_e       hold_q;
  logic [N:0]  held_sel_q;
  logic [PW-1:0] ptr_nxt;

  // Bit 0 of sel is the completion producer, bits N:1 the bulk producers.
  always_comb begin
    if (hold_q == HOLD_BUSY) begin
      sel = held_sel_q;
    end else if (cpl_req) begin
      sel = {{N{1'b0}}, 1'b1};
    end else begin
      sel = {rr_gnt, 1'b0};
    end
  end

  // Preferred index after the bulk producer currently selected.
  always_comb begin
    ptr_nxt = ptr;
    for (int unsigned i = 0; i < N; i++) begin
      if (sel[i+1]) begin
        ptr_nxt = (i + 1 == N) ? '0 : PW'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q     <= HOLD_OPEN;
      held_sel_q <= '0;
      ptr        <= '0;
    end else if (fire) begin
      if (fire_last) begin
        hold_q     <= HOLD_OPEN;
        held_sel_q <= '0;
        if (!sel[0]) begin
          ptr <= ptr_nxt;
        end
      end else begin
        hold_q     <= HOLD_BUSY;
        held_sel_q <= sel;
      end
    end
  end

endmodule

// File: rtl/tx_stream_mux.sv
module tx_stream_mux #(
  parameter int unsigned NS = 4,
  parameter int unsigned W  = 64
) (
  input  logic [NS-1:0] sel,
  input  logic [NS-1:0] src_valid,
  input  logic [W-1:0]  src_data [NS],
  input  logic [NS-1:0] src_last,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          out_last,
  output logic [NS-1:0] src_ready
);

  // One-hot AND-OR selection keeps the data path shallow.
  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    out_last  = 1'b0;
    for (int unsigned s = 0; s < NS; s++) begin
      out_valid = out_valid | (sel[s] & src_valid[s]);
      out_data  = out_data  | ({W{sel[s]}} & src_data[s]);
      out_last  = out_last  | (sel[s] & src_last[s]);
    end
  end

  assign src_ready = sel & {NS{out_ready}};

endmodule

// File: rtl/tx_pkt_sched.sv
module tx_pkt_sched #(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned N_BULK = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpl_valid,
  input  logic [DATA_W-1:0]        cpl_data,
  input  logic                     cpl_last,
  output logic                     cpl_ready,
  input  logic [N_BULK-1:0]        bulk_valid,
  input  logic [N_BULK*DATA_W-1:0] bulk_data,
  input  logic [N_BULK-1:0]        bulk_last,
  output logic [N_BULK-1:0]        bulk_ready,
  output logic                     out_valid,
  output logic [DATA_W-1:0]        out_data,
  output logic                     out_last,
  input  logic                     out_ready
);

  localparam int unsigned NSRC = N_BULK + 1;
  localparam int unsigned PW   = tx_arb_pkg::idx_w(N_BULK);

  logic [DATA_W-1:0] src_data [NSRC];
  logic [NSRC-1:0]   src_valid;
  logic [NSRC-1:0]   src_last;
  logic [NSRC-1:0]   src_ready;
  logic [NSRC-1:0]   sel;
  logic [N_BULK-1:0] rr_gnt;
  logic [PW-1:0]     ptr;
  logic              fire;

  assign src_data[0] = cpl_data;
  assign src_valid   = {bulk_valid, cpl_valid};
  assign src_last    = {bulk_last, cpl_last};

  for (genvar g = 0; g < N_BULK; g++) begin : g_unpack
    assign src_data[g+1] = bulk_data[g*DATA_W +: DATA_W];
  end

  assign fire       = out_valid & out_ready;
  assign cpl_ready  = src_ready[0];
  assign bulk_ready = src_ready[NSRC-1:1];

  tx_rr_pick #(.N(N_BULK), .PW(PW)) u_pick (
    .req (bulk_valid),
    .ptr (ptr),
    .gnt (rr_gnt)
  );

  tx_arb_ctrl #(.N(N_BULK), .PW(PW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpl_req   (cpl_valid),
    .rr_gnt    (rr_gnt),
    .fire      (fire),
    .fire_last (out_last),
    .ptr       (ptr),
    .sel       (sel)
  );

  tx_stream_mux #(.NS(NSRC), .W(DATA_W)) u_mux (
    .sel       (sel),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_last  (src_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .src_ready (src_ready)
  );

endmodule

// File: rtl/tx_arb_chk.sv
module tx_arb_chk #(
  parameter int unsigned N_BULK = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpl_valid,
  input logic              cpl_ready,
  input logic [N_BULK-1:0] bulk_valid,
  input logic [N_BULK-1:0] bulk_ready,
  input logic              out_valid,
  input logic              out_last,
  input logic              out_ready
);

  logic [N_BULK:0] rdy;
  logic            any_v;
  logic            mid;

  assign rdy   = {bulk_ready, cpl_ready};
  assign any_v = cpl_valid | (|bulk_valid);

  // Independent view of packet boundaries seen at the outbound port.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mid <= 1'b0;
    end else if (out_valid && out_ready) begin
      mid <= !out_last;
    end
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !any_v |-> !out_valid);

  // R2
  cpl_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mid && cpl_valid && out_ready) |-> cpl_ready);

  // R5
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_last) |=> (!out_ready || rdy == $past(rdy)));

  // R6
  cpl_after_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last && cpl_valid) |=> (!out_ready || !cpl_valid || cpl_ready));

  // R7
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rdy));

  // R8
  stall_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> rdy == '0);

  // R9
  work_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mid && any_v && out_ready) |-> out_valid);

endmodule

bind tx_pkt_sched tx_arb_chk #(.N_BULK(N_BULK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpl_valid  (cpl_valid),
  .cpl_ready  (cpl_ready),
  .bulk_valid (bulk_valid),
  .bulk_ready (bulk_ready),
  .out_valid  (out_valid),
  .out_last   (out_last),
  .out_ready  (out_ready)
);

// File: tb/sim_tx_pkt_sched.sv
`timescale 1ns/1ps
module sim_tx_pkt_sched;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  s_valid = '0;
  logic [63:0] s_data [4];
  logic [3:0]  s_last = '0;
  logic        cpl_ready;
  logic [2:0]  bulk_ready;
  logic [191:0] bulk_data;
  logic        out_valid;
  logic [63:0] out_data;
  logic        out_last;
  logic        out_ready = 1'b0;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  int plen [4][$];
  int bidx [4];
  int pcnt [4];
  int ecnt [4];
  logic [64:0] exp_q [$];
  logic [3:0] acc = '0;
  logic [7:0] lf = 8'h5B;
  bit bp_en = 1'b0;
  bit mid = 1'b0;
  int mid_src = 0;

  always #10 clk = ~clk;

  assign bulk_data = {s_data[3], s_data[2], s_data[1]};

  tx_pkt_sched u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpl_valid  (s_valid[0]),
    .cpl_data   (s_data[0]),
    .cpl_last   (s_last[0]),
    .cpl_ready  (cpl_ready),
    .bulk_valid (s_valid[3:1]),
    .bulk_data  (bulk_data),
    .bulk_last  (s_last[3:1]),
    .bulk_ready (bulk_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_last   (out_last),
    .out_ready  (out_ready)
  );

  function automatic logic [63:0] word(input int s, input int p, input int b);
    return {8'(s), 8'(p), 16'(b), 32'hCAFE0001};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [64:0] act, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Driver side: queue a packet on producer s (0 = completion, 1..3 = bulk index 0..2).
  task automatic push(input int s, input int len);
    plen[s].push_back(len);
  endtask

  // Scoreboard side: the packet the requirements say comes out next.
  task automatic expect_pkt(input int s, input int len);
    for (int b = 0; b < len; b++) begin
      exp_q.push_back({(b == len - 1), word(s, ecnt[s], b)});
    end
    ecnt[s]++;
  endtask

  function automatic bit busy();
    bit r = (exp_q.size() != 0);
    for (int s = 0; s < 4; s++) if (plen[s].size() != 0) r = 1'b1;
    return r;
  endfunction

  task automatic drain();
    int n = 0;
    while (busy() && n < 3000) begin
      @(posedge clk);
      n++;
    end
    chk(!busy(), cur_req, "scenario drained", 65'(exp_q.size()), 65'd0);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // Producer models and output monitor: drive at the falling edge, sample a quarter period later.
  initial begin
    for (int s = 0; s < 4; s++) s_data[s] = '0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        acc = '0;
        continue;
      end
      for (int s = 0; s < 4; s++) begin
        if (acc[s]) begin
          bidx[s]++;
          if (bidx[s] == plen[s][0]) begin
            void'(plen[s].pop_front());
            bidx[s] = 0;
            pcnt[s]++;
          end
        end
      end
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      out_ready = bp_en ? lf[0] : 1'b1;
      for (int s = 0; s < 4; s++) begin
        if (plen[s].size() != 0) begin
          s_valid[s] = 1'b1;
          s_data[s]  = word(s, pcnt[s], bidx[s]);
          s_last[s]  = (bidx[s] == plen[s][0] - 1);
        end else begin
          s_valid[s] = 1'b0;
          s_data[s]  = '0;
          s_last[s]  = 1'b0;
        end
      end
      #5;
      acc = s_valid & {bulk_ready, cpl_ready};
      if (s_valid == 4'b0000)
        chk(!out_valid, "R1", "out_valid with no producer valid", 65'(out_valid), 65'd0);
      if (!out_ready)
        chk({bulk_ready, cpl_ready} == 4'b0000, "R8", "ready seen while stalled",
            65'({bulk_ready, cpl_ready}), 65'd0);
      if (out_valid && out_ready) begin
        int src = 0;
        for (int s = 0; s < 4; s++) if (acc[s]) src = s;
        chk($countones(acc) == 1, "R7", "accepting producer count", 65'(acc), 65'd1);
        chk({out_last, out_data} == {s_last[src], s_data[src]}, "R7", "output matches granted producer",
            {out_last, out_data}, {s_last[src], s_data[src]});
        if (mid)
          chk(src == mid_src, "R5", "packet interleaved", 65'(src), 65'(mid_src));
        mid = !out_last;
        mid_src = src;
        if (exp_q.size() == 0) begin
          chk(1'b0, cur_req, "unexpected beat", {out_last, out_data}, 65'd0);
        end else begin
          logic [64:0] e;
          e = exp_q.pop_front();
          chk({out_last, out_data} == e, cur_req, "beat order", {out_last, out_data}, e);
        end
      end
    end
  end

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) begin
      bidx[s] = 0; pcnt[s] = 0; ecnt[s] = 0;
    end
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #6;
    // R1: reset state, nothing offered
    chk(!out_valid, "R1", "out_valid after reset", 65'(out_valid), 65'd0);
    chk({bulk_ready, cpl_ready} == 4'b0000, "R1", "ready after reset",
        65'({bulk_ready, cpl_ready}), 65'd0);
    @(posedge clk); #1;

    // R3: all bulk producers full, two packets each
    cur_req = "R3";
    for (int r = 0; r < 2; r++) begin
      for (int s = 1; s < 4; s++) begin
        push(s, 2);
        expect_pkt(s, 2);
      end
    end
    drain();

    // R2: completion offered alongside every bulk producer; rotation back at index 0
    cur_req = "R2";
    push(0, 1); push(1, 3); push(2, 3); push(3, 3);
    expect_pkt(0, 1); expect_pkt(1, 3); expect_pkt(2, 3); expect_pkt(3, 3);
    drain();

    // R4/R9: lone bulk index 1 moves preference to index 2; completion must not move it
    cur_req = "R4";
    push(2, 2);
    expect_pkt(2, 2);
    drain();
    cur_req = "R4/R9";
    push(0, 2); push(1, 2); push(3, 2);
    expect_pkt(0, 2); expect_pkt(3, 2); expect_pkt(1, 2);
    drain();

    // R6: completion arrives two beats into a six-beat bulk packet
    cur_req = "R6";
    push(2, 6);
    expect_pkt(2, 6);
    repeat (2) @(posedge clk);
    #1;
    push(0, 2); push(3, 1);
    expect_pkt(0, 2); expect_pkt(3, 1);
    drain();

    // R8: mixed batch under random back-pressure, order unchanged
    cur_req = "R8";
    bp_en = 1'b1;
    push(0, 1); push(1, 3); push(2, 2); push(3, 2); push(1, 1);
    expect_pkt(0, 1); expect_pkt(1, 3); expect_pkt(2, 2); expect_pkt(3, 2); expect_pkt(1, 1);
    drain();
    bp_en = 1'b0;
    repeat (2) @(posedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule